// File: doc/BRIEF.md
# Clock Failure Detector with Injectable Test Fault

This block watches one clock through a timebase taken from a reference clock. The reference-clock cycles are grouped into fixed monitor windows. If a window ends with no rising edge seen on the watched clock, the block declares a clock failure. The watched clock is brought into the reference domain by a flop synchronizer, and its rising edges become one-cycle pulses. One or more counted pulses in a window means the clock is healthy.

Software can set a test bit to create a failure on purpose. The window that is already running when the bit is set finishes normally. The window after it is fully blanked: every synchronized edge is discarded, so that window is guaranteed to look dead. At the end of the blanked window the test bit clears itself.

Every failure sets a sticky flag and sends a one-cycle report to the error controller. This applies to a real failure and to an injected one alike. The rest of the response depends on which clock is watched and on what drives the main clock:
- If a clock other than the main clock is watched, nothing more happens.
- If the main clock is watched and it comes from an external source, the block pulses a request to move the main clock to the internal high-frequency oscillator.
- If the main clock is watched and it comes from any other source, the block pulses a machine-check reset request.

While an injected fault blanks a window on the main clock, the block also holds a request for a clean stop of the main clock. The glitch-free stop itself is done outside this block.

Top module: `clk_fail_detect`

## Requirements
- R1: While reset is held, every output is 0: `fail_flag`, `test_busy`, `err_report`, `switch_req`, `reset_req` and `mclk_stop_req`.
- R2: A window of INTERVAL_CYC reference cycles that contains at least one counted rising edge of `mon_clk` produces no failure. A rising edge reaches the counting stage SYNC_STAGES cycles after it is sampled.
- R3: A window with no counted edge raises `err_report` in the first cycle after the window ends. Windows end every INTERVAL_CYC cycles, counted from reset release.
- R4: `fail_flag` is set by any failure and stays set until `flag_clr` is 1. If a failure and a clear arrive in the same cycle, the failure wins.
- R5: A `test_wr` pulse raises `test_busy` from the next cycle. The window after the current one is blanked. The injected failure is reported between INTERVAL_CYC and 2*INTERVAL_CYC-1 cycles after the edge that samples `test_wr`, and `test_busy` returns to 0 in that same cycle.
- R6: The window that is running when `test_wr` arrives is not blanked, so its edges still count. A `test_wr` sampled in the last cycle of a window blanks the very next window.
- R7: When `src_sel` is not 0, a failure pulses neither `switch_req` nor `reset_req`.
- R8: When `src_sel` is 0 and `main_src` is 1 (crystal oscillator) or 2 (external clock input), a failure pulses `switch_req` together with `err_report`.
- R9: When `src_sel` is 0 and `main_src` is 0 (internal high-frequency oscillator) or 3 (low-power oscillator), a failure pulses `reset_req` together with `err_report`.
- R10: `err_report`, `switch_req` and `reset_req` are single-cycle pulses, and `switch_req` and `reset_req` are never high together.
- R11: `mclk_stop_req` is 1 exactly during a blanked window while `src_sel` is 0.
- R12: A `test_wr` pulse while `test_busy` is 1 is ignored. It neither restarts nor extends the pending test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all logic runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_clk | input | 1 | Watched clock, sampled asynchronously |
| src_sel | input | SRC_W | Watched source; 0 means the main clock |
| main_src | input | 2 | Main clock source: 0 int HF osc, 1 crystal, 2 ext input, 3 low-power osc |
| test_wr | input | 1 | One-cycle write that starts a fault injection |
| flag_clr | input | 1 | One-cycle write-1 clear of the failure flag |
| fail_flag | output | 1 | Sticky failure flag |
| test_busy | output | 1 | Test bit readback; clears itself after the blanked window |
| err_report | output | 1 | One-cycle failure report to the error controller |
| switch_req | output | 1 | One-cycle request to fall back to the internal HF oscillator |
| reset_req | output | 1 | One-cycle machine-check reset request |
| mclk_stop_req | output | 1 | Clean-stop request held through an injected main-clock fault |

## Verification
An edge driven on `mon_clk` counts SYNC_STAGES reference cycles later. Failure outputs and the flag appear one cycle after the last cycle of the window they judge. `test_busy` rises one cycle after `test_wr` is sampled and falls in the same cycle as the injected report. `mclk_stop_req` follows the test state and `src_sel` with no register delay.

The bench keeps its own per-cycle model, built from these counts, of cycle index, window index and blanked-window index. It compares every output in every cycle at the falling clock edge, before it changes any input. Directed cases place the trigger at the first, a middle and the last cycle of a window, and check the measured report latency against 2*INTERVAL_CYC-1 minus the trigger offset.

// File: rtl/cfd_pkg.sv
`timescale 1ns/1ps
package cfd_pkg;

  // main clock source encoding (field decoded by the response logic)
  typedef enum logic [1:0] {
    MSRC_INT_HF  = 2'd0,
    MSRC_XTAL    = 2'd1,
    MSRC_EXT_IN  = 2'd2,
    MSRC_LOWPWR  = 2'd3
  } main_src_e;

  typedef enum logic [1:0] {
    ACT_FLAG_ONLY  = 2'd0,
    ACT_FALLBACK   = 2'd1,
    ACT_MCHK_RESET = 2'd2
  } fail_action_e;

  typedef enum logic [1:0] {
    TST_IDLE  = 2'd0,
    TST_ARMED = 2'd1,
    TST_BLANK = 2'd2
  } test_state_e;

  // the main clock is fed from outside the chip
  function automatic logic main_is_external(input logic [1:0] msrc);
    return (msrc == MSRC_XTAL) || (msrc == MSRC_EXT_IN);
  endfunction

  // response chosen on a detected failure
  function automatic fail_action_e pick_action(input logic watch_main,
                                               input logic [1:0] msrc);
    fail_action_e act;
    if (!watch_main)                 act = ACT_FLAG_ONLY;
    else if (main_is_external(msrc)) act = ACT_FALLBACK;
    else                             act = ACT_MCHK_RESET;
    return act;
  endfunction

  // width of a counter that spans n states
  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/cfd_edge_sync.sv
`timescale 1ns/1ps
module cfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pls
);
  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0] chain;
  logic          last_q;

  for (genvar i = 0; i < NS; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[NS-1];
  end

  assign rise_pls = chain[NS-1] & ~last_q;

endmodule

// File: rtl/cfd_interval_timer.sv
`timescale 1ns/1ps
module cfd_interval_timer #(
  parameter int INTERVAL_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic interval_end
);
  import cfd_pkg::*;

  localparam int CW = cnt_width(INTERVAL_CYC);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign interval_end = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (interval_end) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/cfd_window_judge.sv
`timescale 1ns/1ps
module cfd_window_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_pls,
  input  logic blank,
  input  logic interval_end,
  output logic edge_counted,
  output logic seen_q,
  output logic fail_det
);

  assign edge_counted = edge_pls & ~blank;
  assign fail_det     = interval_end & ~(seen_q | edge_counted);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            seen_q <= 1'b0;
    else if (interval_end) seen_q <= 1'b0;
    else if (edge_counted) seen_q <= 1'b1;
  end

endmodule

// File: rtl/cfd_test_ctrl.sv
`timescale 1ns/1ps
module cfd_test_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic test_wr,
  input  logic interval_end,
  output logic busy,
  output logic blank
);
  import cfd_pkg::*;

  test_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      TST_IDLE:  if (test_wr)      st_d = interval_end ? TST_BLANK : TST_ARMED;
      TST_ARMED: if (interval_end) st_d = TST_BLANK;
      TST_BLANK: if (interval_end) st_d = TST_IDLE;
      default:                     st_d = TST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TST_IDLE;
    else        st_q <= st_d;
  end

  assign busy  = (st_q != TST_IDLE);
  assign blank = (st_q == TST_BLANK);

endmodule

// File: rtl/cfd_response.sv
`timescale 1ns/1ps
module cfd_response (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fail_det,
  input  logic       watch_main,
  input  logic [1:0] main_src,
  input  logic       flag_clr,
  output logic       fail_flag,
  output logic       err_report,
  output logic       switch_req,
  output logic       reset_req
);
  import cfd_pkg::*;

  fail_action_e act;
  assign act = pick_action(watch_main, main_src);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_flag  <= 1'b0;
      err_report <= 1'b0;
      switch_req <= 1'b0;
      reset_req  <= 1'b0;
    end else begin
      err_report <= fail_det;
      switch_req <= fail_det && (act == ACT_FALLBACK);
      reset_req  <= fail_det && (act == ACT_MCHK_RESET);
      if (fail_det)      fail_flag <= 1'b1;
      else if (flag_clr) fail_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/clk_fail_detect.sv
`timescale 1ns/1ps
module clk_fail_detect #(
  parameter int INTERVAL_CYC = 32,
  parameter int SYNC_STAGES  = 2,
  parameter int SRC_W        = 2
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             mon_clk,
  input  logic [SRC_W-1:0] src_sel,
  input  logic [1:0]       main_src,
  input  logic             test_wr,
  input  logic             flag_clr,
  output logic             fail_flag,
  output logic             test_busy,
  output logic             err_report,
  output logic             switch_req,
  output logic             reset_req,
  output logic             mclk_stop_req
);

  // named internal events, also watched by the checker
  logic edge_pls;
  logic edge_counted;
  logic seen_q;
  logic interval_end;
  logic fail_det;
  logic blank;
  logic watch_main;

  assign watch_main = (src_sel == '0);

  cfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .async_in (mon_clk),
    .rise_pls (edge_pls)
  );

  cfd_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk          (clk_ref),
    .rst_n        (rst_n),
    .interval_end (interval_end)
  );

  cfd_test_ctrl u_test (
    .clk          (clk_ref),
    .rst_n        (rst_n),
    .test_wr      (test_wr),
    .interval_end (interval_end),
    .busy         (test_busy),
    .blank        (blank)
  );

  cfd_window_judge u_judge (
    .clk          (clk_ref),
    .rst_n        (rst_n),
    .edge_pls     (edge_pls),
    .blank        (blank),
    .interval_end (interval_end),
    .edge_counted (edge_counted),
    .seen_q       (seen_q),
    .fail_det     (fail_det)
  );

  cfd_response u_resp (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .fail_det   (fail_det),
    .watch_main (watch_main),
    .main_src   (main_src),
    .flag_clr   (flag_clr),
    .fail_flag  (fail_flag),
    .err_report (err_report),
    .switch_req (switch_req),
    .reset_req  (reset_req)
  );

  // an injected fault on the main clock asks for a clean stop of it
  assign mclk_stop_req = blank & watch_main;

endmodule

// File: rtl/clk_fail_detect_chk.sv
`timescale 1ns/1ps
module clk_fail_detect_chk #(
  parameter int SRC_W = 2
) (
  input logic             clk_ref,
  input logic             rst_n,
  input logic [SRC_W-1:0] src_sel,
  input logic [1:0]       main_src,
  input logic             flag_clr,
  input logic             fail_flag,
  input logic             test_busy,
  input logic             err_report,
  input logic             switch_req,
  input logic             reset_req,
  input logic             edge_pls,
  input logic             edge_counted,
  input logic             seen_q,
  input logic             interval_end,
  input logic             fail_det,
  input logic             blank
);

  // R2: a window that saw an edge yields no report
  assert_healthy_quiet_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (interval_end && (seen_q || edge_counted)) |=> !err_report);

  // R3: a window with no edge yields a report
  assert_dead_reports_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (interval_end && !seen_q && !edge_counted) |=> err_report);

  // R4: flag holds unless cleared
  assert_flag_sticky_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (fail_flag && !flag_clr) |=> fail_flag);

  // R4: a failure always leaves the flag set
  assert_flag_set_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    fail_det |=> fail_flag);

  // R5: a blanked window drops every edge
  assert_blank_drops_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    blank |-> !edge_counted);

  // R5: end of the blanked window reports and clears the test bit
  assert_inject_end_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (blank && interval_end) |=> (err_report && !test_busy));

  // R7: watching another clock never switches or resets
  assert_flag_only_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (fail_det && src_sel != '0) |=> (!switch_req && !reset_req));

  // R8: external main clock falls back
  assert_fallback_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (fail_det && src_sel == '0 && (main_src == 2'd1 || main_src == 2'd2)) |=> switch_req);

  // R9: internal main clock asks for a machine-check reset
  assert_mchk_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (fail_det && src_sel == '0 && (main_src == 2'd0 || main_src == 2'd3)) |=> reset_req);

  // R10: single-cycle reports, exclusive requests
  assert_err_pulse_R10: assert property (@(posedge clk_ref) disable iff (!rst_n)
    err_report |=> !err_report);

  assert_req_excl_R10: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $onehot0({switch_req, reset_req}));

  // R12: the test bit cannot clear before a blanked window has ended
  assert_busy_hold_R12: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (test_busy && !(blank && interval_end)) |=> test_busy);

endmodule

bind clk_fail_detect clk_fail_detect_chk #(.SRC_W(SRC_W)) u_chk (
  .clk_ref      (clk_ref),
  .rst_n        (rst_n),
  .src_sel      (src_sel),
  .main_src     (main_src),
  .flag_clr     (flag_clr),
  .fail_flag    (fail_flag),
  .test_busy    (test_busy),
  .err_report   (err_report),
  .switch_req   (switch_req),
  .reset_req    (reset_req),
  .edge_pls     (edge_pls),
  .edge_counted (edge_counted),
  .seen_q       (seen_q),
  .interval_end (interval_end),
  .fail_det     (fail_det),
  .blank        (blank)
);

// File: tb/clk_fail_detect_bench.sv
`timescale 1ns/1ps
module clk_fail_detect_bench;

  localparam int N    = 32;
  localparam int SYNC = 2;

  logic       clk_ref = 1'b0;
  logic       rst_n   = 1'b0;
  logic       mon_clk = 1'b0;
  logic [1:0] src_sel = 2'd1;
  logic [1:0] main_src = 2'd1;
  logic       test_wr = 1'b0;
  logic       flag_clr = 1'b0;
  logic       fail_flag, test_busy, err_report, switch_req, reset_req, mclk_stop_req;

  always #2.5 clk_ref = ~clk_ref;

  clk_fail_detect #(.INTERVAL_CYC(N), .SYNC_STAGES(SYNC), .SRC_W(2)) u_clk_fail_detect (
    .clk_ref(clk_ref), .rst_n(rst_n), .mon_clk(mon_clk), .src_sel(src_sel),
    .main_src(main_src), .test_wr(test_wr), .flag_clr(flag_clr),
    .fail_flag(fail_flag), .test_busy(test_busy), .err_report(err_report),
    .switch_req(switch_req), .reset_req(reset_req), .mclk_stop_req(mclk_stop_req)
  );

  int total = 0;
  int bad   = 0;
  int k     = 0;

  // bench model state
  logic e_err = 0, e_sw = 0, e_rst = 0, e_flag = 0, e_busy = 0;
  logic m_seen = 0, mon_last = 0;
  logic [SYNC-1:0] rise_hist = '0;
  int   m_blank_idx = -1;

  // stimulus state
  bit mon_alive = 1;
  int half_per = 3, tog_cnt = 0;

  // observation
  int err_cnt = 0, sw_cnt = 0, rst_cnt = 0, stop_cnt = 0, last_err_k = -1;
  logic prev_err = 0;
  int dbl_cnt = 0;

  // 0 flag only, 1 fallback, 2 machine-check reset
  function automatic int expect_action(input logic [1:0] s, input logic [1:0] m);
    if (s != 2'd0) return 0;
    if (m == 2'd1 || m == 2'd2) return 1;
    return 2;
  endfunction

  function automatic int inject_latency(input int trig_cycle);
    return 2 * N - (trig_cycle % N) - 1;
  endfunction

  task automatic chk(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d: got %0b expected %0b", tag, k, got, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s cycle %0d: got %0d expected %0d", tag, k, got, exp);
    end
  endtask

  task automatic check_outputs();
    logic e_stop;
    e_stop = e_busy && (k / N == m_blank_idx) && (src_sel == 2'd0);
    chk("R3 err_report", err_report, e_err);
    chk("R8 switch_req", switch_req, e_sw);
    chk("R9 reset_req", reset_req, e_rst);
    chk("R4 fail_flag", fail_flag, e_flag);
    chk("R5 test_busy", test_busy, e_busy);
    chk("R11 mclk_stop_req", mclk_stop_req, e_stop);
    if (err_report) begin err_cnt++; last_err_k = k; end
    if (switch_req) sw_cnt++;
    if (reset_req) rst_cnt++;
    if (mclk_stop_req) stop_cnt++;
    if (err_report && prev_err) dbl_cnt++;
    prev_err = err_report;
  endtask

  task automatic mon_step();
    if (mon_alive) begin
      if (tog_cnt == 0) begin
        mon_clk = ~mon_clk;
        tog_cnt = half_per;
      end else tog_cnt--;
    end
  endtask

  task automatic model_update();
    logic pulse, blanked, last, fail, nbusy;
    int act;
    pulse     = rise_hist[SYNC-1];
    rise_hist = {rise_hist[SYNC-2:0], (mon_clk && !mon_last)};
    mon_last  = mon_clk;
    blanked   = e_busy && (k / N == m_blank_idx);
    if (pulse && !blanked) m_seen = 1;
    last = (k % N == N - 1);
    fail = last && !m_seen;
    act  = expect_action(src_sel, main_src);
    nbusy = e_busy;
    if (!e_busy && test_wr) begin
      nbusy = 1;
      m_blank_idx = k / N + 1;
    end else if (e_busy && last && (k / N == m_blank_idx)) nbusy = 0;
    e_err  = fail;
    e_sw   = fail && act == 1;
    e_rst  = fail && act == 2;
    e_flag = fail ? 1'b1 : (flag_clr ? 1'b0 : e_flag);
    e_busy = nbusy;
    if (last) m_seen = 0;
  endtask

  task automatic step(input bit tw, input bit fc, input bit rnd);
    check_outputs();
    if (rnd && (k % N == 0)) begin
      src_sel   = 2'($urandom % 4);
      main_src  = 2'($urandom % 4);
      mon_alive = ($urandom % 5) != 0;
      half_per  = 1 + int'($urandom % 5);
    end
    mon_step();
    test_wr  = tw | (rnd && ($urandom % 40 == 0));
    flag_clr = fc | (rnd && ($urandom % 16 == 0));
    model_update();
    @(negedge clk_ref);
    k++;
  endtask

  task automatic run_until(input int target);
    while (k < target) step(0, 0, 0);
  endtask

  task automatic run_to_offset(input int off);
    while (k % N != off) step(0, 0, 0);
  endtask

  // directed injection: returns measured latency
  task automatic inject_at(input int off, output int lat, output int pre_errs);
    int c, e0;
    run_to_offset(off);
    c  = k;
    e0 = err_cnt;
    step(1, 0, 0);
    run_until((c / N + 1) * N + 1);
    pre_errs = err_cnt - e0;
    run_until((c / N + 2) * N + 1);
    lat = last_err_k - (c + 1);
  endtask

  bit done = 0;

  initial begin
    repeat (150000) @(posedge clk_ref);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog cycle %0d: got hang expected finish", k);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lat, pre, e0, s0, r0, st0, want;
    void'($urandom(32'd20240611));

    // R1: reset state
    repeat (3) @(negedge clk_ref);
    chk("R1 fail_flag", fail_flag, 0);
    chk("R1 test_busy", test_busy, 0);
    chk("R1 err_report", err_report, 0);
    chk("R1 switch_req", switch_req, 0);
    chk("R1 reset_req", reset_req, 0);
    chk("R1 mclk_stop_req", mclk_stop_req, 0);
    rst_n = 1'b1;

    // R2: healthy clock, several rates, no failure
    src_sel = 2'd1; main_src = 2'd1;
    e0 = err_cnt;
    for (int hp = 1; hp <= 5; hp++) begin
      half_per = hp;
      run_until(k + 2 * N);
    end
    chk_int("R2 healthy windows report count", err_cnt - e0, 0);

    // R3 + R7: dead clock while watching a non-main source
    run_to_offset(0);
    mon_alive = 0;
    e0 = err_cnt; s0 = sw_cnt; r0 = rst_cnt;
    run_until(k + 3 * N + 1);
    chk_int("R3 dead windows reported", (err_cnt - e0 >= 2) ? 1 : 0, 1);
    chk_int("R7 no switch on non-main watch", sw_cnt - s0, 0);
    chk_int("R7 no reset on non-main watch", rst_cnt - r0, 0);
    chk("R4 flag held after failures", fail_flag, 1);

    // R4: clear the flag with a live clock
    mon_alive = 1; half_per = 2;
    run_until(k + 5);
    step(0, 1, 0);
    run_until(k + 2);
    chk("R4 flag cleared", fail_flag, 0);

    // R5 + R6 + R8 + R11: inject mid-window, main clock from crystal
    src_sel = 2'd0; main_src = 2'd1;
    s0 = sw_cnt; st0 = stop_cnt;
    inject_at(5, lat, pre);
    chk_int("R6 running window not blanked", pre, 0);
    chk_int("R5 latency mid window", lat, inject_latency(5));
    chk_int("R8 switch requested", sw_cnt - s0, 1);
    chk_int("R11 stop held through blanked window", stop_cnt - st0, N);
    chk("R5 test bit self-cleared", test_busy, 0);

    // R5 + R6 + R9: trigger in last cycle of a window, low-power main
    main_src = 2'd3;
    r0 = rst_cnt;
    inject_at(N - 1, lat, pre);
    chk_int("R5 latency at window end", lat, N);
    chk_int("R9 reset requested", rst_cnt - r0, 1);

    // R5 + R9: trigger at window start, internal HF main
    main_src = 2'd0;
    r0 = rst_cnt;
    inject_at(0, lat, pre);
    chk_int("R5 latency at window start", lat, 2 * N - 1);
    chk_int("R9 reset requested int HF", rst_cnt - r0, 1);

    // R12: second trigger while busy is ignored; R8 on external input
    main_src = 2'd2;
    run_to_offset(3);
    want = k;
    e0 = err_cnt; s0 = sw_cnt;
    step(1, 0, 0);
    run_until(want + N);
    step(1, 0, 0);
    run_until((want / N + 2) * N + 1);
    chk_int("R12 single report", err_cnt - e0, 1);
    chk_int("R12 report time kept", last_err_k - (want + 1), inject_latency(want));
    chk_int("R8 switch on external input", sw_cnt - s0, 1);
    run_until(k + 3 * N);
    chk_int("R12 no late second report", err_cnt - e0, 1);

    // random mix
    for (int i = 0; i < 60 * N; i++) step(0, 0, 1);
    test_wr = 0; flag_clr = 0;
    run_until(k + 3 * N);

    chk_int("R10 back-to-back reports", dbl_cnt, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule